// File: doc/BRIEF.md
# Timestamp LRU Frame Tracker

This block keeps a small set of page frames and decides, for every page reference it is given, whether the page is already resident or must be brought in. Each frame records a page id, an occupied flag and a recency stamp. A free-running reference clock advances by one on every accepted reference. When a reference finds its page, the current clock value is copied into that frame's stamp. When it does not, the block picks a frame to overwrite. It takes a free frame first. If no frame is free, it takes the frame with the smallest stamp, which is the least recently referenced one. It then loads the new page id and the current clock into that frame.

A reference is presented for one cycle with `ref_valid` high. One cycle later the block reports the result on `resp_valid`, `resp_hit`, `resp_fault` and `resp_frame`. The frame contents and the running fault total are updated at the same clock edge. Cycles without a reference leave every piece of state untouched, including the reference clock.

Top module: `lru_frame_tracker`

## Requirements
- R1: After a synchronous active-low reset, all frames are empty, `resp_valid` is 0 and `fault_count` is 0.
- R2: A reference to a resident page gives `resp_hit`=1 and `resp_fault`=0, with `resp_frame` equal to the index of the frame that holds the page, and leaves `fault_count` unchanged.
- R3: A reference to a page that is not resident gives `resp_fault`=1 and `resp_hit`=0, and `fault_count` rises by exactly one.
- R4: While any frame is empty, a fault fills the empty frame with the lowest index (frame 0 first), and a filled frame never becomes empty again until reset.
- R5: When all frames are full, a fault replaces the frame whose stamp is smallest, which is the frame referenced least recently. A hit refreshes the stamp of its frame. Equal stamps go to the lowest index.
- R6: The result of a reference appears exactly one clock after `ref_valid` is sampled high. A cycle with `ref_valid`=0 gives `resp_valid`=0 on the next cycle and changes no frame, no stamp and no count.
- R7: With the default 3 frames and starting from reset, the reference string A B C A B D A D B C produces exactly 5 faults.
- R8: A page written by a fault is resident at once, so the next reference to it is a hit in the frame that was reported. A page is never held by two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | A page reference is presented this cycle |
| ref_page | input | PAGE_W | Page id of the reference |
| resp_valid | output | 1 | Result of the previous cycle's reference is valid |
| resp_hit | output | 1 | The referenced page was resident |
| resp_fault | output | 1 | The referenced page was absent and has been loaded |
| resp_frame | output | IDX_W | Frame that was hit or that received the page |
| fault_count | output | CNT_W | Faults since reset |

## Verification
The hardest case to reach from the ports is an eviction in which the frame that was filled first is not the oldest, because earlier hits have refreshed its stamp. Only then does a timestamp LRU give a different answer from a FIFO. The stimulus reaches this case with the reference string, whose hits on A and B move the victim for D to frame 2. A later directed run refreshes frame 1 with a hit just before a fault, so the fault has to skip it and take frame 0. The bench also lets idle cycles pass and then references a resident page, to show that nothing was disturbed.

// File: rtl/lru_pkg.sv
// Package: shared helpers for the LRU frame tracker.
// Assumes: widths are at least one bit.
package lru_pkg;

    // Width of an index that can address n items (minimum 1 bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lru_frame_store.sv
// Module: lru_frame_store
// Holds one page id, one occupied flag and one recency stamp per frame.
// It compares the looked-up page against every occupied frame in parallel.
// A write updates one frame in full: page, occupied flag and stamp.
// Assumes: the caller never loads a page into a second frame while the
// page is already resident.
module lru_frame_store #(
    parameter int NUM_FRAMES = 3,
    parameter int PAGE_W     = 8,
    parameter int STAMP_W    = 16,
    parameter int IDX_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [PAGE_W-1:0]     wr_page,
    input  logic [STAMP_W-1:0]    wr_stamp,
    input  logic [PAGE_W-1:0]     lookup_page,
    output logic [NUM_FRAMES-1:0] valid_vec,
    output logic [STAMP_W-1:0]    stamp_arr [NUM_FRAMES],
    output logic [NUM_FRAMES-1:0] match_vec
);

    logic [PAGE_W-1:0] page_arr [NUM_FRAMES];

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        // Purpose: store the contents of frame g, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
                page_arr[g]  <= '0;
                stamp_arr[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                valid_vec[g] <= 1'b1;
                page_arr[g]  <= wr_page;
                stamp_arr[g] <= wr_stamp;
            end
        end

        // Purpose: flag frame g when it holds the looked-up page.
        always_comb begin
            match_vec[g] = valid_vec[g] && (page_arr[g] == lookup_page);
        end

        // R4: once a frame is filled, it stays filled until reset.
        assert_frame_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(valid_vec[g]) |-> valid_vec[g]);
    end

    // R8: no page may be resident in two frames.
    assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

endmodule

// File: rtl/lru_victim_sel.sv
// Module: lru_victim_sel
// Picks the frame to replace on a fault. An empty frame wins over a
// filled one, and among empty frames the lowest index wins. If every
// frame is filled, the smallest stamp wins, and equal stamps go to the
// lowest index.
// Assumes: the stamps do not wrap while the block is in use.
module lru_victim_sel #(
    parameter int NUM_FRAMES = 3,
    parameter int STAMP_W    = 16,
    parameter int IDX_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FRAMES-1:0] valid_vec,
    input  logic [STAMP_W-1:0]    stamp_arr [NUM_FRAMES],
    output logic [IDX_W-1:0]      victim_idx
);

    // Purpose: linear scan that keeps the best candidate found so far.
    always_comb begin
        logic              best_valid;
        logic [STAMP_W-1:0] best_stamp;
        victim_idx = '0;
        best_valid = valid_vec[0];
        best_stamp = stamp_arr[0];
        for (int i = 1; i < NUM_FRAMES; i++) begin
            if ((best_valid && !valid_vec[i]) ||
                (best_valid && valid_vec[i] && (stamp_arr[i] < best_stamp))) begin
                victim_idx = IDX_W'(i);
                best_valid = valid_vec[i];
                best_stamp = stamp_arr[i];
            end
        end
    end

    // R4: if any frame is empty, the chosen frame is an empty one.
    assert_empty_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (~valid_vec != '0) |-> !valid_vec[victim_idx]);

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_chk
        // R5: with all frames full, no frame is older than the victim.
        assert_oldest_chosen_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (&valid_vec) |-> (stamp_arr[victim_idx] <= stamp_arr[g]));
    end

endmodule

// File: rtl/lru_ref_clock.sv
// Module: lru_ref_clock
// Reference clock and fault total. The clock advances once for each
// accepted reference. The fault total rises once for each fault.
// Assumes: STAMP_W is wide enough that the clock does not wrap in use.
module lru_ref_clock #(
    parameter int STAMP_W = 16,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_accept,
    input  logic               ref_is_fault,
    output logic [STAMP_W-1:0] now_stamp,
    output logic [CNT_W-1:0]   fault_total
);

    // Purpose: advance the reference clock on each accepted reference.
    always_ff @(posedge clk) begin
        if (!rst_n)          now_stamp <= '0;
        else if (ref_accept) now_stamp <= now_stamp + STAMP_W'(1);
    end

    // Purpose: count the references that faulted.
    always_ff @(posedge clk) begin
        if (!rst_n)                          fault_total <= '0;
        else if (ref_accept && ref_is_fault) fault_total <= fault_total + CNT_W'(1);
    end

    // R6: the clock stays put on a cycle with no reference.
    assert_clock_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(ref_accept) |-> $stable(now_stamp));

endmodule

// File: rtl/lru_frame_tracker.sv
// Module: lru_frame_tracker (top)
// Timestamp LRU tracker for page frames. Each reference is looked up
// against all frames. A hit refreshes the frame's stamp. A fault loads
// the page into the frame chosen by lru_victim_sel. The result is
// registered and appears one cycle after the reference.
// Assumes: at most one reference per cycle, and page ids compare exactly.
module lru_frame_tracker #(
    parameter int NUM_FRAMES = 3,
    parameter int PAGE_W     = 8,
    parameter int STAMP_W    = 16,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = lru_pkg::idx_width(NUM_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_valid,
    input  logic [PAGE_W-1:0] ref_page,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_fault,
    output logic [IDX_W-1:0]  resp_frame,
    output logic [CNT_W-1:0]  fault_count
);

    logic [NUM_FRAMES-1:0] valid_vec;
    logic [NUM_FRAMES-1:0] match_vec;
    logic [STAMP_W-1:0]    stamp_arr [NUM_FRAMES];
    logic [STAMP_W-1:0]    now_stamp;
    logic [IDX_W-1:0]      victim_idx;
    logic [IDX_W-1:0]      hit_idx;
    logic [IDX_W-1:0]      sel_idx;
    logic                  is_hit;

    // Purpose: encode the matching frame, lowest index first.
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    // Purpose: pick the frame this reference touches.
    always_comb begin
        is_hit  = |match_vec;
        sel_idx = is_hit ? hit_idx : victim_idx;
    end

    lru_frame_store #(
        .NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W),
        .STAMP_W(STAMP_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ref_valid), .wr_idx(sel_idx),
        .wr_page(ref_page), .wr_stamp(now_stamp),
        .lookup_page(ref_page),
        .valid_vec(valid_vec), .stamp_arr(stamp_arr), .match_vec(match_vec)
    );

    lru_victim_sel #(
        .NUM_FRAMES(NUM_FRAMES), .STAMP_W(STAMP_W), .IDX_W(IDX_W)
    ) u_victim (
        .clk(clk), .rst_n(rst_n),
        .valid_vec(valid_vec), .stamp_arr(stamp_arr),
        .victim_idx(victim_idx)
    );

    lru_ref_clock #(
        .STAMP_W(STAMP_W), .CNT_W(CNT_W)
    ) u_clock (
        .clk(clk), .rst_n(rst_n),
        .ref_accept(ref_valid), .ref_is_fault(!is_hit),
        .now_stamp(now_stamp), .fault_total(fault_count)
    );

    // Purpose: register the result of this cycle's reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_fault <= 1'b0;
            resp_frame <= '0;
        end else begin
            resp_valid <= ref_valid;
            resp_hit   <= ref_valid && is_hit;
            resp_fault <= ref_valid && !is_hit;
            if (ref_valid) resp_frame <= sel_idx;
        end
    end

    // R3: a reported fault comes with a count one higher than before.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && resp_valid && resp_fault |-> fault_count == $past(fault_count) + CNT_W'(1));

    // R2: a reported hit leaves the fault count where it was.
    assert_hit_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && resp_valid && resp_hit |-> $stable(fault_count));

    // R6: a cycle without a reference yields no response on the next one.
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |=> !resp_valid);

    // R2/R3: a valid response is exactly one of hit or fault.
    assert_hit_xor_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_hit != resp_fault));

endmodule

// File: tb/tb_lru_frame_tracker.sv
module tb_lru_frame_tracker;

    localparam int PAGE_W = 8;
    localparam int CNT_W  = 16;
    localparam int NREF   = 10;

    // Reference string A B C A B D A D B C (A=1, B=2, C=3, D=4), with the
    // expected hit flag and frame for each step.
    localparam logic [7:0] VEC_PAGE  [NREF] = '{8'd1, 8'd2, 8'd3, 8'd1, 8'd2, 8'd4, 8'd1, 8'd4, 8'd2, 8'd3};
    localparam logic       VEC_HIT   [NREF] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam logic [1:0] VEC_FRAME [NREF] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd1, 2'd0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_valid = 1'b0;
    logic [PAGE_W-1:0] ref_page = '0;
    logic              resp_valid, resp_hit, resp_fault;
    logic [1:0]        resp_frame;
    logic [CNT_W-1:0]  fault_count;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    lru_frame_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .ref_valid(ref_valid), .ref_page(ref_page),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
        .resp_frame(resp_frame), .fault_count(fault_count)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one reference and check the response one clock later.
    task automatic reference(input string req, input logic [7:0] page,
                             input logic exp_hit, input logic [1:0] exp_frame,
                             input int exp_count);
        ref_valid = 1'b1;
        ref_page  = page;
        @(negedge clk);
        ref_valid = 1'b0;
        check(req, "resp_valid", resp_valid, 1);
        check(req, "resp_hit", resp_hit, exp_hit);
        check(req, "resp_fault", resp_fault, !exp_hit);
        check(req, "resp_frame", resp_frame, exp_frame);
        check(req, "fault_count", fault_count, exp_count);
    endtask

    initial begin
        int faults;
        do_reset();
        // R1: reset state.
        check("R1", "resp_valid after reset", resp_valid, 0);
        check("R1", "fault_count after reset", fault_count, 0);

        // R7 with R2, R3, R4, R5: walk the reference string.
        faults = 0;
        for (int i = 0; i < NREF; i++) begin
            if (!VEC_HIT[i]) faults++;
            reference("R7", VEC_PAGE[i], VEC_HIT[i], VEC_FRAME[i], faults);
        end
        check("R7", "faults for reference string", fault_count, 5);

        // R6: idle cycles produce no response and change nothing.
        repeat (4) begin
            @(negedge clk);
            check("R6", "resp_valid while idle", resp_valid, 0);
            check("R6", "fault_count while idle", fault_count, 5);
        end
        // R6/R8: C still resident in frame 0 after idling.
        reference("R8", 8'd3, 1'b1, 2'd0, 5);
        // R5: E (5) evicts the oldest frame 2 (D).
        reference("R5", 8'd5, 1'b0, 2'd2, 6);
        // R8: E is resident at once in the frame reported.
        reference("R8", 8'd5, 1'b1, 2'd2, 6);
        // R2: hit on B refreshes frame 1.
        reference("R2", 8'd2, 1'b1, 2'd1, 6);
        // R5: F (6) must skip refreshed frame 1 and take frame 0 (C).
        reference("R5", 8'd6, 1'b0, 2'd0, 7);
        // R3: C was evicted, so it faults and takes the oldest frame 2 (E).
        reference("R3", 8'd3, 1'b0, 2'd2, 8);

        // R1/R4: after reset, frames are empty and fill from frame 0.
        do_reset();
        check("R1", "fault_count after second reset", fault_count, 0);
        check("R1", "resp_valid after second reset", resp_valid, 0);
        reference("R4", 8'd2, 1'b0, 2'd0, 1);
        reference("R4", 8'd9, 1'b0, 2'd1, 2);
        reference("R4", 8'd2, 1'b1, 2'd0, 2);
        reference("R4", 8'd7, 1'b0, 2'd2, 3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule